// File: doc/BRIEF.md
# Bus Cycle Wait-State Timer

This block decides how long each processor bus cycle lasts, in master-clock cycles, and signals when the cycle ends. When a bus cycle starts, the block takes the target address, a flag marking an internal (no memory) cycle, a fast-ROM enable bit and a region class that has already been decoded. From these it picks a length of 6, 8 or 12 master cycles. It then counts down and raises a one-clock done pulse in the last master cycle of the access.

The processor bus is paused once per scanline for memory refresh. While the stall input is high, the count stops and no cycle can complete. The stall therefore stretches the access by exactly the number of stalled clocks. The length is captured when the start strobe is accepted, so the address and mode inputs may change freely while the cycle runs. A new start strobe in the done cycle is accepted at once, so accesses can run back to back.

Top module: `bus_wait_timer`

## Requirements
- R1: An internal cycle (internal_i = 1) lasts 6 master cycles whatever the region, address or fast-ROM bit.
- R2: A ROM access (region_i = 2'b00) lasts 6 master cycles when fast_en_i = 1 and addr_i[23] = 1 (address 0x800000 or above).
- R3: Any other ROM access (fast_en_i = 0, or address below 0x800000) lasts 8 master cycles.
- R4: A work-RAM access (region_i = 2'b01) lasts 8 master cycles.
- R5: A general I/O register access (region_i = 2'b10) lasts 6 master cycles.
- R6: A serial controller-port register access (region_i = 2'b11) lasts 12 master cycles.
- R7: The access length is the number of clocks from the first cycle after the accepting edge up to and including the done cycle. done_o is high for exactly one clock, in that final cycle.
- R8: The length is captured when start is accepted. Later changes to addr_i, region_i, fast_en_i or internal_i during the access have no effect on it.
- R9: A start_i that is high in the done cycle is accepted at the next edge, giving back-to-back accesses with no idle clock.
- R10: While stall_i is high during an access, done_o stays low and the count holds. Each stalled clock lengthens the access by one.
- R11: A start_i raised while an access is running and not in its done cycle is ignored. After done, busy_o falls and no further access starts.
- R12: While rst_ni is low, and after its release with no start, done_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Bus cycle start strobe |
| addr_i | input | 24 | Access address |
| internal_i | input | 1 | Internal cycle, no memory touched |
| fast_en_i | input | 1 | Fast-ROM enable |
| region_i | input | 2 | Region class: 00 ROM, 01 work RAM, 10 I/O, 11 serial port |
| stall_i | input | 1 | Refresh stall, holds the cycle open |
| busy_o | output | 1 | An access is in progress (through its done cycle) |
| done_o | output | 1 | Last master cycle of the access |

## Verification
The hardest case to reach is a stall that lands on the very cycle that would otherwise be the done cycle. In that cycle the countdown has already reached zero, and only the stall keeps the access open. The bench drives a random stall on every clock of many accesses, and it also drives one long 40-clock stall block. Together these put stalls both on the final cycle and on earlier counting cycles. In every case the bench expects the length to equal the region's length plus the number of stalled clocks. During those runs the bench also changes the attributes and pulses start in the middle of an access, to show that neither has any effect.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  typedef enum logic [1:0] {
    RGN_ROM    = 2'b00,
    RGN_WRAM   = 2'b01,
    RGN_IO     = 2'b10,
    RGN_SERIAL = 2'b11
  } region_e;
endpackage

// File: rtl/bwt_len_sel.sv
module bwt_len_sel
  import bwt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FAST_LEN = 6,
  parameter int SLOW_LEN = 8,
  parameter int XSLOW_LEN = 12,
  localparam int CNT_W = $clog2(XSLOW_LEN + 1)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              internal_i,
  input  logic              fast_en_i,
  input  region_e           region_i,
  output logic [CNT_W-1:0]  len_o
);
  logic upper_half;
  assign upper_half = addr_i[ADDR_W-1];

  always_comb begin
    if (internal_i) len_o = CNT_W'(FAST_LEN);
    else begin
      unique case (region_i)
        RGN_ROM:    len_o = (fast_en_i && upper_half) ? CNT_W'(FAST_LEN) : CNT_W'(SLOW_LEN);
        RGN_WRAM:   len_o = CNT_W'(SLOW_LEN);
        RGN_IO:     len_o = CNT_W'(FAST_LEN);
        RGN_SERIAL: len_o = CNT_W'(XSLOW_LEN);
        default:    len_o = CNT_W'(SLOW_LEN);
      endcase
    end
  end

  // R1: internal cycles always use the short length
  always_comb a_r1_internal_fast: assert (!internal_i || len_o == CNT_W'(FAST_LEN));
  // R6: only the three legal lengths
  always_comb a_r6_legal_len: assert (len_o == CNT_W'(FAST_LEN) || len_o == CNT_W'(SLOW_LEN)
                                      || len_o == CNT_W'(XSLOW_LEN));
endmodule

// File: rtl/bwt_counter.sv
module bwt_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             stall_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] rem_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (rem_q == '0) && !stall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      rem_q  <= len_i - CNT_W'(1);
      busy_q <= 1'b1;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q && !stall_i && rem_q != '0) begin
      rem_q <= rem_q - CNT_W'(1);
    end
  end

  a_r8_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !load_i && !stall_i && rem_q != '0) |=> (busy_q && rem_q == $past(rem_q) - CNT_W'(1)));
  a_r10_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && stall_i && !load_i) |=> (busy_q && $stable(rem_q)));
  a_r7_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !done_o);
endmodule

// File: rtl/bus_wait_timer.sv
module bus_wait_timer
  import bwt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FAST_LEN = 6,
  parameter int SLOW_LEN = 8,
  parameter int XSLOW_LEN = 12,
  localparam int CNT_W = $clog2(XSLOW_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              internal_i,
  input  logic              fast_en_i,
  input  logic [1:0]        region_i,
  input  logic              stall_i,
  output logic              busy_o,
  output logic              done_o
);
  logic [CNT_W-1:0] len;
  logic             load;

  bwt_len_sel #(
    .ADDR_W(ADDR_W), .FAST_LEN(FAST_LEN), .SLOW_LEN(SLOW_LEN), .XSLOW_LEN(XSLOW_LEN)
  ) i_len_sel (
    .addr_i    (addr_i),
    .internal_i(internal_i),
    .fast_en_i (fast_en_i),
    .region_i  (region_e'(region_i)),
    .len_o     (len)
  );

  // accept when idle or on the final cycle (back-to-back)
  assign load = start_i && (!busy_o || done_o);

  bwt_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .len_i  (len),
    .stall_i(stall_i),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  a_r10_no_done_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !done_o);
  a_r11_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: tb/test_bus_wait_timer.sv
module test_bus_wait_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] addr = '0;
  logic        intl = 1'b0;
  logic        fast = 1'b0;
  logic [1:0]  rgn = 2'b00;
  logic        stall = 1'b0;
  logic        busy, done;

  int n_chk = 0;
  int n_bad = 0;

  bus_wait_timer i_bus_wait_timer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .internal_i(intl), .fast_en_i(fast), .region_i(rgn), .stall_i(stall),
    .busy_o(busy), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(logic [1:0] r, logic [23:0] a, bit f, bit i);
    if (i) return 6;
    case (r)
      2'b00: return (f && a >= 24'h800000) ? 6 : 8;
      2'b01: return 8;
      2'b10: return 6;
      default: return 12;
    endcase
  endfunction

  // stall_mode: 0 none, 1 random per clock, 2 block of 40 from cycle 3
  task automatic run_access(logic [1:0] r, logic [23:0] a, bit f, bit i,
                            bit scramble, int stall_mode, bit poke, string tag);
    int cnt = 1;
    int stalls = 0;
    int exp = exp_len(r, a, f, i);
    @(negedge clk);
    start = 1'b1; rgn = r; addr = a; fast = f; intl = i; stall = 1'b0;
    @(posedge clk); #1;
    forever begin
      start = (poke && cnt == 1);
      if (scramble) begin
        rgn = 2'($urandom); addr = 24'($urandom); fast = 1'($urandom); intl = 1'($urandom);
      end
      case (stall_mode)
        1: stall = ($urandom % 4 == 0);
        2: stall = (cnt >= 3 && cnt < 43);
        default: stall = 1'b0;
      endcase
      if (stall) stalls++;
      #1;
      if (!busy) chk(0, "R7 busy during access", 0, 1);
      if (done && stall) chk(0, "R10 done during stall", 1, 0);
      if (done || cnt > 300) break;
      @(posedge clk); #1;
      cnt++;
    end
    stall = 1'b0; start = 1'b0;
    chk(cnt == exp + stalls, tag, cnt, exp + stalls);
    if (poke) begin
      @(posedge clk); #2;
      chk(!busy && !done, "R11 ignored start leaves idle", int'(busy), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    start = 1'b1;
    repeat (3) @(posedge clk);
    #2 chk(!done && !busy, "R12 in reset", int'(done | busy), 0);
    @(negedge clk); start = 1'b0; rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2 chk(!done && !busy, "R12 after reset", int'(done | busy), 0);

    run_access(2'b00, 24'h800000, 1, 0, 0, 0, 0, "R2 fast rom upper");
    run_access(2'b00, 24'hFFFFFF, 1, 0, 0, 0, 0, "R2 fast rom top");
    run_access(2'b00, 24'h7FFFFF, 1, 0, 0, 0, 0, "R3 fast en lower half");
    run_access(2'b00, 24'h800000, 0, 0, 0, 0, 0, "R3 fast off upper");
    run_access(2'b00, 24'h000000, 0, 0, 0, 0, 0, "R3 fast off lower");
    run_access(2'b01, 24'h7E0000, 1, 0, 0, 0, 0, "R4 wram");
    run_access(2'b01, 24'h800000, 1, 0, 0, 0, 0, "R4 wram upper");
    run_access(2'b10, 24'h002100, 0, 0, 0, 0, 0, "R5 io");
    run_access(2'b10, 24'h802100, 1, 0, 0, 0, 0, "R5 io upper");
    run_access(2'b11, 24'h004016, 0, 0, 0, 0, 0, "R6 serial");
    run_access(2'b11, 24'h804017, 1, 0, 0, 0, 0, "R6 serial upper");
    run_access(2'b11, 24'h004016, 0, 1, 0, 0, 0, "R1 internal over serial");
    run_access(2'b00, 24'h123456, 0, 1, 0, 0, 0, "R1 internal over rom");
    run_access(2'b00, 24'h000000, 0, 0, 1, 0, 0, "R8 scrambled slow rom");
    run_access(2'b11, 24'h000000, 0, 0, 1, 0, 0, "R8 scrambled serial");
    run_access(2'b01, 24'h000000, 0, 0, 0, 2, 0, "R10 refresh block");
    run_access(2'b10, 24'h000000, 0, 0, 0, 1, 0, "R10 random stall");
    run_access(2'b11, 24'h000000, 0, 0, 0, 0, 1, "R11 start while busy");
    // back-to-back: next start lands in the done cycle
    run_access(2'b10, 24'h000000, 0, 0, 0, 0, 0, "R9 first");
    run_access(2'b11, 24'h000000, 0, 0, 0, 0, 0, "R9 back to back");

    for (int k = 0; k < 300; k++) begin
      logic [1:0]  r = 2'($urandom);
      logic [23:0] a = 24'($urandom);
      bit f = 1'($urandom);
      bit i = ($urandom % 5 == 0);
      run_access(r, a, f, i, 1'($urandom), int'($urandom % 2), ($urandom % 6 == 0),
                 "R7 random access length");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule